// File: doc/BRIEF.md
# Watchdog / Periodic Alarm Down Counter

This block is a loadable down counter with a seed register. Software writes the count one byte at a time. Each write updates the seed and restarts the count from the whole seed. Reads return a frozen copy of the count, so a multibyte read stays consistent while the counter keeps moving. A mode input picks one of two behaviours. In periodic-alarm mode the counter steps on a slow once-per-second enable, raises an alarm flag at expiry, reloads itself and runs again. In watchdog mode it steps on a fast 4096 Hz enable. Any access to a counter byte restarts it, and at expiry it raises the flag and stops.

A watchdog expiry can start a fixed-length low pulse on either the reset line or the interrupt line. A steering input chooses the line. The pulse lasts a parameterised number of fast ticks, 1024 by default (a quarter second). Software cannot cut it short. While the reset pulse is active, all counter and flag accesses are ignored. When the counter is disabled, or when its seed is all zero, it holds its value and acts as plain storage. After a write takes the seed from zero to nonzero, the enable input must rise again before counting resumes. Bus decoding and the control register itself live outside the block. Its configuration arrives as level inputs.

Top module: `wdalm_counter`

## Requirements
- R1: A write of byte k (byte 0 is bits 7:0, byte 1 is bits 15:8, byte 2 is bits 23:16) replaces that byte of the seed and loads the whole count from the updated seed in the same clock. When counting is disabled, the count reads back unchanged however many ticks arrive.
- R2: A read strobe loads cntRdData at the next clock edge. Reading byte 0 copies the whole live count into a snapshot and returns its byte 0. Reading bytes 1 and 2 returns bytes of that snapshot, not of the live count.
- R3: With cfgCountEnable at 0, or with an all-zero seed, the count does not step and the alarm flag is never set, whatever the tick inputs do.
- R4: In alarm mode (cfgWatchdogMode = 0) a seed N sets alarmFlag on the N-th slow tick after the load and reloads N, so the flag comes every N slow ticks; fast ticks have no effect. Writing flagWrData = 0 clears the flag; writing 1 leaves it unchanged.
- R5: In alarm mode irqDriveLow equals alarmFlag AND cfgIrqEnable for either value of cfgSteerIrq.
- R6: In watchdog mode (cfgWatchdogMode = 1) the counter steps on fast ticks only. A read or write of any counter byte restarts it from the seed. At zero it sets alarmFlag, and the count stays 0.
- R7: In watchdog mode with cfgSteerIrq = 0, expiry drives rstDriveLow for PULSE_TICKS fast ticks. During that time counter reads, counter writes and flag writes are ignored. At release the alarm flag is cleared.
- R8: In watchdog mode with cfgSteerIrq = 1 and cfgIrqEnable = 1, expiry drives irqDriveLow for PULSE_TICKS fast ticks, then clears the flag. With cfgIrqEnable = 0 there is no pulse and the flag stays set.
- R9: A running pulse ends only on its last fast tick. Clearing the flag or cfgIrqEnable does not shorten it. A counter write made during an interrupt pulse updates the seed, and the count is loaded from it when the pulse ends.
- R10: A write that takes the seed from all-zero to nonzero stops counting until cfgCountEnable goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tickSlow | input | 1 | One-cycle enable, once per second |
| tickFast | input | 1 | One-cycle enable, 4096 per second |
| cntByteSel | input | 2 | Counter byte select for reads and writes |
| cntWrEn | input | 1 | Counter byte write strobe |
| cntWrData | input | 8 | Counter byte write data |
| cntRdEn | input | 1 | Counter byte read strobe |
| cntRdData | output | 8 | Registered counter byte read data |
| flagWrEn | input | 1 | Alarm flag write strobe |
| flagWrData | input | 1 | Alarm flag write value (0 clears) |
| cfgCountEnable | input | 1 | Counter enable |
| cfgWatchdogMode | input | 1 | 0 periodic alarm, 1 watchdog |
| cfgSteerIrq | input | 1 | Watchdog pulse on interrupt (1) or reset (0) line |
| cfgIrqEnable | input | 1 | Interrupt enable |
| alarmFlag | output | 1 | Alarm flag |
| irqDriveLow | output | 1 | 1 pulls the open-drain interrupt line low |
| rstDriveLow | output | 1 | 1 pulls the open-drain reset line low |

## Verification
On every cycle the assertions check the reset pulse and its flag. The pulse rises only with the flag set. It cannot end except on a fast tick. While it is low the flag stays set and the read data stays frozen. At release the flag is clear. The assertions also check that every rise of the flag falls on the tick that belongs to the selected mode. The bench scenarios show the things that depend on counted history: the exact expiry tick for a sweep of seeds in both modes, restart on read, snapshot consistency across bytes, the deferred reload after an interrupt pulse, and the re-arming rule.

// File: rtl/wdalm_pkg.sv
package wdalm_pkg;
  // Strobes from the control module to the datapath, valid for one cycle.
  typedef struct packed {
    logic seedWr;     // replace the selected seed byte
    logic reload;     // count <= (updated) seed
    logic dec;        // count <= count - 1
    logic rdCapture;  // register read data for the selected byte
  } dpCmd_t;
endpackage

// File: rtl/wdalm_datapath.sv
module wdalm_datapath
  import wdalm_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int SEL_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCmd_t            cmd,
  input  logic [SEL_W-1:0]  byteSel,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              countIsZero,
  output logic              countIsOne,
  output logic              seedIsZero,
  output logic              nextSeedIsZero
);
  localparam int CNT_W = BYTE_W * NUM_BYTES;

  logic [CNT_W-1:0]  seed, count, snapshot, nextSeed;
  logic [BYTE_W-1:0] snapByte;

  always_comb begin
    nextSeed = seed;
    snapByte = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (byteSel == SEL_W'(b)) begin
        if (cmd.seedWr) nextSeed[b*BYTE_W +: BYTE_W] = wrData;
        snapByte = snapshot[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign countIsZero    = (count == '0);
  assign countIsOne     = (count == CNT_W'(1));
  assign seedIsZero     = (seed == '0);
  assign nextSeedIsZero = (nextSeed == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed  <= '0;
      count <= '0;
    end else begin
      seed <= nextSeed;
      if (cmd.reload)   count <= nextSeed;
      else if (cmd.dec) count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snapshot <= '0;
      rdData   <= '0;
    end else if (cmd.rdCapture) begin
      if (byteSel == '0) begin
        snapshot <= count;
        rdData   <= count[BYTE_W-1:0];
      end else begin
        rdData <= snapByte;
      end
    end
  end
endmodule

// File: rtl/wdalm_pulse_timer.sv
module wdalm_pulse_timer #(
  parameter int PULSE_TICKS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(PULSE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);

  logic [CW-1:0] tickCnt;

  assign done = busy && tick && (tickCnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      tickCnt <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      tickCnt <= '0;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy && tick) begin
      tickCnt <= tickCnt + CW'(1);
    end
  end
endmodule

// File: rtl/wdalm_ctrl.sv
module wdalm_ctrl
  import wdalm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tickSlow,
  input  logic   tickFast,
  input  logic   cntWrEn,
  input  logic   cntRdEn,
  input  logic   flagWrEn,
  input  logic   flagWrData,
  input  logic   cfgCountEnable,
  input  logic   cfgWatchdogMode,
  input  logic   cfgSteerIrq,
  input  logic   cfgIrqEnable,
  input  logic   countIsZero,
  input  logic   countIsOne,
  input  logic   seedIsZero,
  input  logic   nextSeedIsZero,
  input  logic   pulseBusy,
  input  logic   pulseDone,
  output dpCmd_t cmd,
  output logic   pulseStart,
  output logic   alarmFlag,
  output logic   irqDriveLow,
  output logic   rstDriveLow
);
  logic armed, enPrev, flagQ, rstLine, irqLine, pendingReload;
  logic blocked, wrOk, rdOk, active, tickSel, accessReload, stepNow, expire;

  assign blocked      = rstLine;
  assign wrOk         = cntWrEn && !blocked;
  assign rdOk         = cntRdEn && !blocked;
  assign active       = cfgCountEnable && armed && !seedIsZero;
  assign tickSel      = cfgWatchdogMode ? tickFast : tickSlow;
  assign accessReload = wrOk || (rdOk && cfgWatchdogMode && active);
  assign stepNow      = active && !pulseBusy && !accessReload && tickSel && !countIsZero;
  assign expire       = stepNow && countIsOne;

  always_comb begin
    cmd.seedWr    = wrOk;
    cmd.rdCapture = rdOk;
    cmd.reload    = (!pulseBusy && accessReload)
                 || (pulseDone && (pendingReload || accessReload))
                 || (expire && !cfgWatchdogMode);
    cmd.dec       = stepNow && !(expire && !cfgWatchdogMode);
  end

  assign pulseStart  = expire && cfgWatchdogMode && (!cfgSteerIrq || cfgIrqEnable);
  assign alarmFlag   = flagQ;
  assign rstDriveLow = rstLine;
  assign irqDriveLow = irqLine || (!cfgWatchdogMode && flagQ && cfgIrqEnable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed         <= 1'b0;
      enPrev        <= 1'b0;
      flagQ         <= 1'b0;
      rstLine       <= 1'b0;
      irqLine       <= 1'b0;
      pendingReload <= 1'b0;
    end else begin
      enPrev <= cfgCountEnable;
      // r10_: zero-to-nonzero seed write disarms until enable rises again
      if (wrOk && seedIsZero && !nextSeedIsZero) armed <= 1'b0;
      else if (cfgCountEnable && !enPrev)        armed <= 1'b1;

      if (expire)                                               flagQ <= 1'b1;
      else if (pulseDone)                                       flagQ <= 1'b0;
      else if (flagWrEn && !flagWrData && !pulseBusy && !blocked) flagQ <= 1'b0;

      if (pulseStart) begin
        rstLine <= !cfgSteerIrq;
        irqLine <= cfgSteerIrq;
      end else if (pulseDone) begin
        rstLine <= 1'b0;
        irqLine <= 1'b0;
      end

      if (pulseDone)                       pendingReload <= 1'b0;
      else if (pulseBusy && accessReload)  pendingReload <= 1'b1;
    end
  end
endmodule

// File: rtl/wdalm_counter.sv
module wdalm_counter
  import wdalm_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int NUM_BYTES   = 3,
  parameter int PULSE_TICKS = 1024,
  localparam int SEL_W      = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickSlow,
  input  logic              tickFast,
  input  logic [SEL_W-1:0]  cntByteSel,
  input  logic              cntWrEn,
  input  logic [BYTE_W-1:0] cntWrData,
  input  logic              cntRdEn,
  output logic [BYTE_W-1:0] cntRdData,
  input  logic              flagWrEn,
  input  logic              flagWrData,
  input  logic              cfgCountEnable,
  input  logic              cfgWatchdogMode,
  input  logic              cfgSteerIrq,
  input  logic              cfgIrqEnable,
  output logic              alarmFlag,
  output logic              irqDriveLow,
  output logic              rstDriveLow
);
  dpCmd_t cmd;
  logic countIsZero, countIsOne, seedIsZero, nextSeedIsZero;
  logic pulseStart, pulseBusy, pulseDone;

  wdalm_ctrl u_ctrl (
    .clk, .rst_n, .tickSlow, .tickFast, .cntWrEn, .cntRdEn,
    .flagWrEn, .flagWrData, .cfgCountEnable, .cfgWatchdogMode,
    .cfgSteerIrq, .cfgIrqEnable, .countIsZero, .countIsOne,
    .seedIsZero, .nextSeedIsZero, .pulseBusy, .pulseDone,
    .cmd, .pulseStart, .alarmFlag, .irqDriveLow, .rstDriveLow
  );

  wdalm_datapath #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .SEL_W(SEL_W)) u_dp (
    .clk, .rst_n, .cmd, .byteSel(cntByteSel), .wrData(cntWrData),
    .rdData(cntRdData), .countIsZero, .countIsOne, .seedIsZero, .nextSeedIsZero
  );

  wdalm_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk, .rst_n, .start(pulseStart), .tick(tickFast),
    .busy(pulseBusy), .done(pulseDone)
  );
endmodule

// File: rtl/wdalm_checker.sv
module wdalm_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tickSlow,
  input logic              tickFast,
  input logic              cntRdEn,
  input logic [BYTE_W-1:0] cntRdData,
  input logic              cfgWatchdogMode,
  input logic              alarmFlag,
  input logic              irqDriveLow,
  input logic              rstDriveLow
);
  // R4, R6: the flag only rises on the tick belonging to the selected mode
  a_r4_flag_on_mode_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarmFlag) |-> $past(cfgWatchdogMode ? tickFast : tickSlow));

  // R7: a reset pulse starts together with the flag
  a_r7_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstDriveLow) |-> alarmFlag);

  // R7: release of the reset line leaves the flag clear
  a_r7_flag_clear_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rstDriveLow) |-> !alarmFlag);

  // R7: reads are ignored while the reset line is held low
  a_r7_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (rstDriveLow && cntRdEn) |=> $stable(cntRdData));

  // R9: the pulse can only end on a fast tick
  a_r9_no_truncate: assert property (@(posedge clk) disable iff (!rst_n)
    (rstDriveLow && !tickFast) |=> rstDriveLow);

  // R9: the flag survives inside a running pulse
  a_r9_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (alarmFlag && rstDriveLow && !tickFast) |=> alarmFlag);

  // R5, R8: the interrupt line never goes low without the flag
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqDriveLow) |-> alarmFlag);
endmodule

bind wdalm_counter wdalm_checker #(.BYTE_W(BYTE_W)) u_wdalm_checker (
  .clk, .rst_n, .tickSlow, .tickFast, .cntRdEn, .cntRdData,
  .cfgWatchdogMode, .alarmFlag, .irqDriveLow, .rstDriveLow
);

// File: tb/tb_wdalm_counter.sv
module tb_wdalm_counter;
  localparam int PULSE = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tickSlow = 0, tickFast = 0;
  logic [1:0] cntByteSel = '0;
  logic cntWrEn = 0, cntRdEn = 0, flagWrEn = 0, flagWrData = 0;
  logic [7:0] cntWrData = '0;
  logic [7:0] cntRdData;
  logic cfgCountEnable = 0, cfgWatchdogMode = 0, cfgSteerIrq = 0, cfgIrqEnable = 0;
  logic alarmFlag, irqDriveLow, rstDriveLow;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wdalm_counter #(.BYTE_W(8), .NUM_BYTES(3), .PULSE_TICKS(PULSE)) dut (
    .clk, .rst_n, .tickSlow, .tickFast, .cntByteSel, .cntWrEn, .cntWrData,
    .cntRdEn, .cntRdData, .flagWrEn, .flagWrData, .cfgCountEnable,
    .cfgWatchdogMode, .cfgSteerIrq, .cfgIrqEnable, .alarmFlag,
    .irqDriveLow, .rstDriveLow
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slow(input int n);
    repeat (n) begin
      @(negedge clk) tickSlow = 1;
      @(negedge clk) tickSlow = 0;
    end
  endtask

  task automatic fast(input int n);
    repeat (n) begin
      @(negedge clk) tickFast = 1;
      @(negedge clk) tickFast = 0;
    end
  endtask

  task automatic wrByte(input int sel, input int data);
    @(negedge clk) begin cntByteSel = 2'(sel); cntWrData = 8'(data); cntWrEn = 1; end
    @(negedge clk) cntWrEn = 0;
  endtask

  task automatic rdByte(input int sel, output int data);
    @(negedge clk) begin cntByteSel = 2'(sel); cntRdEn = 1; end
    @(negedge clk) cntRdEn = 0;
    data = int'(cntRdData);
  endtask

  task automatic wrFlag(input bit v);
    @(negedge clk) begin flagWrData = v; flagWrEn = 1; end
    @(negedge clk) flagWrEn = 0;
  endtask

  task automatic setEnable(input bit v);
    @(negedge clk) cfgCountEnable = v;
    idle(1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int d, b1, b2, expWd;
    idle(3);
    rst_n = 1;
    idle(1);
    // Reset state
    check("R3 reset flag", alarmFlag, 0);
    check("R8 reset irq", irqDriveLow, 0);
    check("R7 reset rst", rstDriveLow, 0);
    check("R2 reset rdata", cntRdData, 0);

    // R1 / R3: disabled counter is plain storage
    wrByte(0, 'h12); wrByte(1, 'h34); wrByte(2, 'h56);
    slow(5); fast(5);
    rdByte(0, d); rdByte(1, b1); rdByte(2, b2);
    check("R1 storage readback", (b2 << 16) | (b1 << 8) | d, 'h563412);
    check("R3 disabled no flag", alarmFlag, 0);

    // R10: zero-to-nonzero write needs enable to rise again
    wrByte(0, 0); wrByte(1, 0); wrByte(2, 0);
    setEnable(1);
    wrByte(0, 3);
    slow(5);
    check("R10 disarmed no flag", alarmFlag, 0);
    rdByte(0, d);
    check("R10 disarmed count held", d, 3);
    setEnable(0); setEnable(1);
    slow(2);
    check("R10 armed before expiry", alarmFlag, 0);
    slow(1);
    check("R10 armed expiry", alarmFlag, 1);

    // R4: alarm mode sweep over seeds
    for (int n = 1; n <= 4; n++) begin
      wrByte(0, n);
      wrFlag(0);
      for (int k = 1; k <= 2 * n; k++) begin
        slow(1); fast(1);
        check($sformatf("R4 seed %0d tick %0d flag", n, k), alarmFlag, (k >= n) ? 1 : 0);
      end
      rdByte(0, d);
      check($sformatf("R4 seed %0d reloaded", n), d, n);
    end
    wrFlag(1);
    check("R4 write one keeps flag", alarmFlag, 1);

    // R5: interrupt level in alarm mode, steering ignored
    for (int s = 0; s < 2; s++) begin
      @(negedge clk) begin cfgSteerIrq = s[0]; cfgIrqEnable = 0; end
      idle(1);
      check($sformatf("R5 steer %0d ie0", s), irqDriveLow, 0);
      @(negedge clk) cfgIrqEnable = 1;
      idle(1);
      check($sformatf("R5 steer %0d ie1", s), irqDriveLow, 1);
    end
    wrFlag(0);
    check("R4 flag cleared", alarmFlag, 0);
    check("R5 irq follows flag", irqDriveLow, 0);

    // R2: snapshot consistency
    wrByte(2, 'h02); wrByte(1, 'h01); wrByte(0, 'h00);
    rdByte(0, d);
    check("R2 byte0 first", d, 'h00);
    slow(1);
    rdByte(1, d);
    check("R2 byte1 from snapshot", d, 'h01);
    rdByte(2, d);
    check("R2 byte2 from snapshot", d, 'h02);
    rdByte(0, d);
    check("R2 byte0 new snapshot", d, 'hFF);
    rdByte(1, d);
    check("R2 byte1 new snapshot", d, 'h00);

    // R6: watchdog sweep, no pulse (steer irq, irq disabled)
    @(negedge clk) begin cfgWatchdogMode = 1; cfgSteerIrq = 1; cfgIrqEnable = 0; end
    for (int m = 1; m <= 5; m++) begin
      wrByte(0, m); wrByte(1, 0); wrByte(2, 0);
      wrFlag(0);
      fast(m - 1); slow(3);
      check($sformatf("R6 seed %0d before read", m), alarmFlag, 0);
      rdByte(0, d);
      check($sformatf("R6 seed %0d read value", m), d, 1);
      fast(m - 1);
      check($sformatf("R6 seed %0d restarted", m), alarmFlag, 0);
      fast(1);
      check($sformatf("R6 seed %0d expiry", m), alarmFlag, 1);
      check($sformatf("R8 seed %0d no irq pulse", m), irqDriveLow, 0);
      fast(3);
      rdByte(0, d);
      check($sformatf("R6 seed %0d stopped at zero", m), d, 0);
    end

    // R7: reset pulse, blocked accesses
    @(negedge clk) cfgSteerIrq = 0;
    wrByte(0, 2);
    wrFlag(0);
    rdByte(0, d);
    check("R7 pre-read", d, 2);
    fast(2);
    check("R7 rst low", rstDriveLow, 1);
    check("R7 flag set", alarmFlag, 1);
    wrFlag(0);
    check("R7 flag write ignored", alarmFlag, 1);
    rdByte(0, d);
    check("R7 read ignored", d, 2);
    wrByte(0, 5);
    fast(PULSE - 1);
    check("R9 rst still low", rstDriveLow, 1);
    fast(1);
    check("R7 rst released", rstDriveLow, 0);
    check("R7 flag cleared", alarmFlag, 0);
    rdByte(0, d);
    check("R7 count stopped", d, 0);
    rdByte(0, d);
    check("R7 blocked write ignored", d, 2);

    // R8 / R9: interrupt pulse, no truncation, deferred write
    @(negedge clk) begin cfgSteerIrq = 1; cfgIrqEnable = 1; end
    wrByte(0, 2);
    fast(2);
    check("R8 irq low", irqDriveLow, 1);
    check("R8 rst idle", rstDriveLow, 0);
    @(negedge clk) cfgIrqEnable = 0;
    wrFlag(0);
    wrByte(0, 3);
    check("R9 irq not truncated", irqDriveLow, 1);
    check("R9 flag not cleared", alarmFlag, 1);
    fast(PULSE - 1);
    check("R9 irq full length", irqDriveLow, 1);
    fast(1);
    check("R8 irq released", irqDriveLow, 0);
    check("R8 flag cleared at end", alarmFlag, 0);
    fast(2);
    check("R9 deferred seed counting", alarmFlag, 0);
    fast(1);
    expWd = 1;
    check("R9 deferred seed expiry", alarmFlag, expWd);
    check("R8 ie0 no pulse", irqDriveLow, 0);
    idle(3);
    check("R8 ie0 flag stays", alarmFlag, 1);

    // R3: all-zero seed disables even when enabled
    @(negedge clk) cfgWatchdogMode = 0;
    wrByte(0, 0);
    wrFlag(0);
    slow(5); fast(5);
    check("R3 zero seed no flag", alarmFlag, 0);
    rdByte(0, d);
    check("R3 zero seed count", d, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule